// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Channel

The block is one channel of a two-way bus register. It moves a word from an A bus to a B bus, and a second word from the B bus back to the A bus. Each direction has its own storage element and three controls: an active-low output enable, a latch enable and a data clock.

While the latch enable of a direction is high, the storage is transparent and the output follows the input with no delay. While the latch enable is low, the storage keeps its value. A rising edge on that direction's data clock then loads the present input. The data clocks are ordinary signals from outside the block. They are sampled against the system clock `clk` through a parameterised synchronizer, and each rising edge is detected from the previous sampled level.

Pad tri-stating is represented by one drive-enable output per bus. A test-mode input overrides both directions. It places externally supplied words on the outputs, turns both drivers on and freezes the stored data. Two instances with shared controls form a path twice as wide.

Top module: `bidir_bus_reg`

## Requirements
- R1: After reset, both stored words are zero. With the latch enables low and the output enables low, `b_out` and `a_out` read 0 and both drive enables read 1.
- R2: While a direction's latch enable is high and test mode is off, its output equals its input in the same cycle, with no clock edge needed.
- R3: While the latch enable is low and the data clock stays at a steady level, the output keeps its stored word even when the input changes.
- R4: While the latch enable is low, a low-to-high transition of the data clock loads the input. The new word appears on the output within SYNC_STAGES+2 system clock cycles.
- R5: When the latch enable falls, the stored word is the input present while the enable was still high.
- R6: A direction's drive enable is 1 when its active-low output enable is 0, and 0 when it is 1. The data output keeps its value either way.
- R7: The two directions are independent. The controls and input of one direction never change the other direction's output.
- R8: While `test_en` is 1, `b_out` equals `test_b`, `a_out` equals `test_a`, and both drive enables are 1. The stored words do not change, so after `test_en` returns to 0 with the latch enables low, the outputs show the words held before test mode.
- R9: A high-to-low transition of a data clock loads nothing.
- R10: A data clock held high through reset is not taken as a rising edge when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears both stored words |
| a_in | input | W | A bus input data |
| b_in | input | W | B bus input data |
| oe_ab_n | input | 1 | Active-low output enable, A-to-B |
| le_ab | input | 1 | Latch enable, A-to-B (high = transparent) |
| ck_ab | input | 1 | Data clock, A-to-B (rising edge loads) |
| oe_ba_n | input | 1 | Active-low output enable, B-to-A |
| le_ba | input | 1 | Latch enable, B-to-A |
| ck_ba | input | 1 | Data clock, B-to-A |
| test_en | input | 1 | Test mode: override outputs, freeze storage |
| test_a | input | W | Word forced onto the A bus in test mode |
| test_b | input | W | Word forced onto the B bus in test mode |
| b_out | output | W | B bus output data |
| b_oe | output | 1 | B bus drive enable |
| a_out | output | W | A bus output data |
| a_oe | output | 1 | A bus drive enable |

## Verification
The hardest situation to reach is a stored word that differs from the live input while the element is opaque. Only then does a missed hold, a spurious load on a falling edge, or storage disturbed during test mode show at the ports.

The stimulus table therefore loads a word with a clock edge and then changes the input under a steady clock. It drops the latch enable in the same step as an input change. It passes through test mode with the latch enable high and a fresh input, and reads the old word back once test mode ends.

A second reset is applied with both data clocks held high, to show that the release does not look like an edge.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

   typedef enum logic [1:0] {
      MODE_PASS = 2'd0,
      MODE_KEEP = 2'd1,
      MODE_LOAD = 2'd2,
      MODE_TEST = 2'd3
   } bbr_mode_e;

   function automatic bbr_mode_e bbr_pick_mode(input logic tst,
                                               input logic le,
                                               input logic rise);
      if (tst)       return MODE_TEST;
      else if (le)   return MODE_PASS;
      else if (rise) return MODE_LOAD;
      else           return MODE_KEEP;
   endfunction

endpackage

// File: rtl/bbr_edge_det.sv
module bbr_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ck_in,
   output logic rise
);

   logic lvl;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = ck_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '1;
            end else begin
               sync_q[0] <= ck_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sync_q[i] <= sync_q[i-1];
               end
            end
         end
         assign lvl = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   // Previous level resets high: a clock held high across reset is no edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;

   // R4: a detected rising edge lasts exactly one system cycle.
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

   // R9: a falling level is never reported as an edge.
   a_r9_no_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_q && !lvl) |-> !rise);

endmodule

// File: rtl/bbr_dir_stage.sv
module bbr_dir_stage
   import bbr_pkg::*;
#(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic         le,
   input  logic         ck_rise,
   input  logic         oe_n,
   input  logic         tst,
   input  logic [W-1:0] tst_val,
   output logic [W-1:0] dout,
   output logic         drv_en
);

   bbr_mode_e    mode;
   logic [W-1:0] store_q;

   assign mode = bbr_pick_mode(tst, le, ck_rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
      end else begin
         case (mode)
            MODE_PASS, MODE_LOAD: store_q <= din;
            default:              store_q <= store_q;
         endcase
      end
   end

   always_comb begin
      case (mode)
         MODE_TEST: dout = tst_val;
         MODE_PASS: dout = din;
         default:   dout = store_q;
      endcase
   end

   assign drv_en = tst | ~oe_n;

   // R3: an opaque element without a clock edge keeps its word.
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tst && !le && !ck_rise) |=> (store_q == $past(store_q)));

   // R8: test mode leaves the stored word untouched.
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      tst |=> (store_q == $past(store_q)));

   // R4: an edge while opaque captures the input.
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!tst && !le && ck_rise) |=> (store_q == $past(din)));

endmodule

// File: rtl/bidir_bus_reg.sv
module bidir_bus_reg #(
   parameter int W           = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         oe_ab_n,
   input  logic         le_ab,
   input  logic         ck_ab,
   input  logic         oe_ba_n,
   input  logic         le_ba,
   input  logic         ck_ba,
   input  logic         test_en,
   input  logic [W-1:0] test_a,
   input  logic [W-1:0] test_b,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   output logic [W-1:0] a_out,
   output logic         a_oe
);

   localparam int NDIR = 2;   // index 0: A-to-B, index 1: B-to-A

   generate
      if (W < 1) begin : g_bad_width
         $error("bidir_bus_reg: W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("bidir_bus_reg: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [W-1:0] din_v  [NDIR];
   logic [W-1:0] tval_v [NDIR];
   logic [W-1:0] dout_v [NDIR];
   logic         le_v   [NDIR];
   logic         ck_v   [NDIR];
   logic         oen_v  [NDIR];
   logic         rise_v [NDIR];
   logic         drv_v  [NDIR];

   assign din_v[0]  = a_in;    assign din_v[1]  = b_in;
   assign tval_v[0] = test_b;  assign tval_v[1] = test_a;
   assign le_v[0]   = le_ab;   assign le_v[1]   = le_ba;
   assign ck_v[0]   = ck_ab;   assign ck_v[1]   = ck_ba;
   assign oen_v[0]  = oe_ab_n; assign oen_v[1]  = oe_ba_n;

   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_dir
         bbr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .ck_in (ck_v[d]),
            .rise  (rise_v[d])
         );
         bbr_dir_stage #(.W(W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (din_v[d]),
            .le      (le_v[d]),
            .ck_rise (rise_v[d]),
            .oe_n    (oen_v[d]),
            .tst     (test_en),
            .tst_val (tval_v[d]),
            .dout    (dout_v[d]),
            .drv_en  (drv_v[d])
         );
      end
   endgenerate

   assign b_out = dout_v[0];
   assign b_oe  = drv_v[0];
   assign a_out = dout_v[1];
   assign a_oe  = drv_v[1];

   // R2: transparent paths follow their inputs.
   a_r2_pass_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_en && le_ab) |-> (b_out == a_in));
   a_r2_pass_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_en && le_ba) |-> (a_out == b_in));

   // R6: drive enables track the active-low output enables.
   a_r6_enables: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |-> ((b_oe == !oe_ab_n) && (a_oe == !oe_ba_n)));

   // R8: test mode owns both buses.
   a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |-> ((b_out == test_b) && (a_out == test_a) && b_oe && a_oe));

endmodule

// File: tb/bidir_bus_reg_tb.sv
module bidir_bus_reg_tb;

   localparam int W = 9;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] a_in, b_in, test_a, test_b;
   logic         oe_ab_n, le_ab, ck_ab, oe_ba_n, le_ba, ck_ba, test_en;
   logic [W-1:0] b_out, a_out;
   logic         b_oe, a_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bidir_bus_reg #(.W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .oe_ab_n(oe_ab_n), .le_ab(le_ab), .ck_ab(ck_ab),
      .oe_ba_n(oe_ba_n), .le_ba(le_ba), .ck_ba(ck_ba),
      .test_en(test_en), .test_a(test_a), .test_b(test_b),
      .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
   );

   typedef struct packed {
      logic [3:0]   req;
      logic         tst, le_ab, ck_ab, oeab_n, le_ba, ck_ba, oeba_n;
      logic [W-1:0] a, b, xb;
      logic         xboe;
      logic [W-1:0] xa;
      logic         xaoe;
   } vec_t;

   localparam int NV = 12;
   // Fields: req, tst, le_ab, ck_ab, oe_ab_n, le_ba, ck_ba, oe_ba_n,
   //         a_in, b_in, expected b_out, b_oe, a_out, a_oe
   localparam vec_t VECS [NV] = '{
      '{4'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 9'h155,9'h0AA, 9'h000,1'b1, 9'h000,1'b1}, // R1
      '{4'd4, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 9'h155,9'h0AA, 9'h155,1'b1, 9'h000,1'b1}, // R4, R7
      '{4'd3, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 9'h0F0,9'h0AA, 9'h155,1'b1, 9'h000,1'b1}, // R3
      '{4'd9, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 9'h0F0,9'h0AA, 9'h155,1'b1, 9'h000,1'b1}, // R9
      '{4'd2, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 9'h0F0,9'h0AA, 9'h0F0,1'b1, 9'h000,1'b1}, // R2
      '{4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 9'h033,9'h0AA, 9'h0F0,1'b1, 9'h000,1'b1}, // R5
      '{4'd7, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 9'h033,9'h0AA, 9'h0F0,1'b1, 9'h0AA,1'b1}, // R7, R4
      '{4'd6, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 9'h033,9'h0AA, 9'h0F0,1'b0, 9'h0AA,1'b1}, // R6
      '{4'd8, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 9'h111,9'h0AA, 9'h03C,1'b1, 9'h1C3,1'b1}, // R8
      '{4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 9'h111,9'h0AA, 9'h0F0,1'b1, 9'h0AA,1'b1}, // R8
      '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 9'h111,9'h1FF, 9'h0F0,1'b1, 9'h1FF,1'b1}, // R2, R7
      '{4'd6, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 9'h111,9'h1FF, 9'h0F0,1'b1, 9'h1FF,1'b0}  // R6, R5
   };

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic [W-1:0] xb,
                            input logic xboe, input logic [W-1:0] xa,
                            input logic xaoe);
      check(req, "b_out", b_out, xb);
      check(req, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, xboe});
      check(req, "a_out", a_out, xa);
      check(req, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, xaoe});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; a_in = '0; b_in = '0;
      test_a = 9'h1C3; test_b = 9'h03C; test_en = 1'b0;
      oe_ab_n = 1'b0; le_ab = 1'b0; ck_ab = 1'b0;
      oe_ba_n = 1'b0; le_ba = 1'b0; ck_ba = 1'b0;
      @(negedge clk);
      do_reset();
      repeat (2) @(negedge clk);
      check_all("R1", '0, 1'b1, '0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         test_en = VECS[i].tst;
         le_ab   = VECS[i].le_ab;  ck_ab = VECS[i].ck_ab;  oe_ab_n = VECS[i].oeab_n;
         le_ba   = VECS[i].le_ba;  ck_ba = VECS[i].ck_ba;  oe_ba_n = VECS[i].oeba_n;
         a_in    = VECS[i].a;      b_in  = VECS[i].b;
         repeat (5) @(negedge clk);
         check_all($sformatf("R%0d(row %0d)", VECS[i].req, i),
                   VECS[i].xb, VECS[i].xboe, VECS[i].xa, VECS[i].xaoe);
      end

      // R2: same-cycle transparency with no clock edge in between.
      le_ab = 1'b1; oe_ab_n = 1'b0; a_in = 9'h101;
      #1 check("R2", "b_out same cycle", b_out, 9'h101);
      a_in = 9'h0FE;
      #1 check("R2", "b_out same cycle", b_out, 9'h0FE);
      le_ab = 1'b0;
      @(negedge clk);

      // R10: data clocks held high across reset must not load.
      ck_ab = 1'b1; ck_ba = 1'b1; le_ab = 1'b0; le_ba = 1'b0;
      oe_ab_n = 1'b0; oe_ba_n = 1'b0; a_in = 9'h155; b_in = 9'h0AA;
      do_reset();
      repeat (6) @(negedge clk);
      check("R10", "b_out after reset", b_out, 9'h000);
      check("R10", "a_out after reset", a_out, 9'h000);

      // R4 / R9: a full clock cycle after that loads exactly once.
      ck_ab = 1'b0;
      repeat (5) @(negedge clk);
      check("R9", "b_out after fall", b_out, 9'h000);
      ck_ab = 1'b1;
      repeat (5) @(negedge clk);
      check("R4", "b_out after rise", b_out, 9'h155);
      check("R7", "a_out untouched", a_out, 9'h000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule